// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device side of a three-wire serial EEPROM, built as synthesizable logic that runs on a system clock. A host drives chip select, shift clock and serial data in. The block answers on serial data out, together with an output-enable that stands in for a released pin. An organization input picks the word width the host sees: 16-bit words when high, 8-bit words when low. Both views map onto one byte array. The shift clock, chip select and data in are synchronized into the system clock domain, and the block acts on their edges.

Each instruction is framed by a start bit and carries a 2-bit opcode and an address field. The block handles read with a gapless sequential stream, single-word write and erase, whole-array write and erase, and commands that enable or disable programming. Every programming operation is guarded by a write-enable latch that is cleared at reset. A programming operation then runs a self-timed cycle of `PROG_CYC` system clocks. If the host drops chip select and raises it again during that cycle, data out reports busy or ready.

Top module: `ee3w_slave`

## Requirements
- R1: While chip select is high, the block ignores data-in zeros until it sees a 1 on a rising shift clock. That 1 is the start bit. It is followed by a 2-bit opcode, sent MSB first, and then the address field, sent MSB first. The address field is `WA_W` bits in 16-bit mode and `WA_W`+1 bits in 8-bit mode.
- R2: Opcode 10 is read. Once the last address bit is taken, data out drives a single 0 with output-enable high. Each later rising shift clock then presents the next data bit, MSB first.
- R3: A read keeps streaming while chip select stays high. After the last bit of a word, the next rising edge presents the MSB of the word at address+1, with no dummy bit in between. The address wraps from the last location to 0.
- R4: In the 8-bit view, 16-bit word k occupies byte 2k (bits 7:0) and byte 2k+1 (bits 15:8).
- R5: After reset, every byte reads 0xFF, programming is disabled and output-enable is low.
- R6: Opcode 00 uses the top two address bits as a sub-code. 11 enables programming and 00 disables it. While programming is disabled, write, erase, write-all and erase-all leave the array unchanged. Read works in either state.
- R7: Opcode 01 is write. It is followed by one data word of 16 or 8 bits, MSB first, and stores that word at the address with no prior erase.
- R8: Opcode 11 sets the addressed word to all ones. Sub-code 10 sets the whole array to all ones. Sub-code 01 takes one data word and writes it to every location.
- R9: A programming operation runs for `PROG_CYC` clocks, starting after its last data bit (for erase, after its last address bit). If chip select goes low and then high during the cycle, output-enable rises and data out is 0 while the cycle runs and 1 once it has finished.
- R10: Output-enable is low whenever chip select is low. If chip select is raised only after the programming cycle has finished, output-enable stays low.
- R11: Shift-clock activity during a programming cycle is ignored. Such an instruction has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| org_i | input | 1 | Word width: 1 = 16-bit, 0 = 8-bit |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Shift clock from host, asynchronous |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out / ready-busy status |
| do_oe_o | output | 1 | Data-out drive enable (low = released) |

## Verification
The embedded properties assume the host behaves like a slow serial master. Each level of chip select, shift clock and data in is held for several system clocks, well beyond the synchronizer depth. Data in is settled before the shift clock rises. Chip select and the shift clock never toggle in the same clock, and the organization input is steady while chip select is high. The stimulus keeps to this by holding each shift-clock phase for eight system clocks and changing data in only while the shift clock is low. It also leaves whole phases between chip-select transitions and clock activity, and sets the organization input only while chip select is low. Outputs are sampled at the end of each high phase, which lets the synchronized edge reach the output register first.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_HDR,
      S_DATA,
      S_READ,
      S_HOLD
   } ee3w_state_e;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] SUB_LOCK   = 2'b00;
   localparam logic [1:0] SUB_FILL   = 2'b01;
   localparam logic [1:0] SUB_CLRALL = 2'b10;
   localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/ee3w_sync.sv
module ee3w_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ee3w_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] pipe_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
      end else begin
         pipe_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      end
   end

   assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/ee3w_timer.sv
module ee3w_timer #(
   parameter int unsigned CYCLES = 1000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o
);

   localparam int unsigned TW = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("ee3w_timer: CYCLES must be at least 1");
      end
   endgenerate

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (start_i)      cnt_q <= TW'(CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   // A new programming request never lands on a cycle already running (R11)
   p_no_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |-> !busy_o);

endmodule

// File: rtl/ee3w_array.sv
module ee3w_array #(
   parameter int unsigned WA_W = 6
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wide_i,
   input  logic [WA_W:0]   addr_i,
   input  logic            we_one_i,
   input  logic            we_all_i,
   input  logic [15:0]     wdata_i,
   output logic [15:0]     rdata_o
);

   localparam int unsigned BA_W  = WA_W + 1;
   localparam int unsigned DEPTH = 1 << BA_W;

   logic [7:0] mem_q [DEPTH];
   logic [BA_W-1:0] lo_idx, hi_idx;

   assign lo_idx = {addr_i[WA_W-1:0], 1'b0};
   assign hi_idx = {addr_i[WA_W-1:0], 1'b1};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      end else if (we_all_i) begin
         for (int i = 0; i < DEPTH; i++)
            mem_q[i] <= (wide_i && (i % 2 == 1)) ? wdata_i[15:8] : wdata_i[7:0];
      end else if (we_one_i) begin
         if (wide_i) begin
            mem_q[lo_idx] <= wdata_i[7:0];
            mem_q[hi_idx] <= wdata_i[15:8];
         end else begin
            mem_q[addr_i] <= wdata_i[7:0];
         end
      end
   end

   assign rdata_o = wide_i ? {mem_q[hi_idx], mem_q[lo_idx]} : {8'h00, mem_q[addr_i]};

   // Whole-array and single-word strobes are never raised together (R8)
   p_one_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_all_i && we_one_i));

endmodule

// File: rtl/ee3w_slave.sv
module ee3w_slave
   import ee3w_pkg::*;
#(
   parameter int unsigned WA_W        = 6,
   parameter int unsigned PROG_CYC    = 1000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic org_i,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   output logic do_o,
   output logic do_oe_o
);

   localparam int unsigned BA_W  = WA_W + 1;
   localparam int unsigned HDR_W = BA_W + 2;
   localparam int unsigned HC_W  = $clog2(HDR_W + 1);

   generate
      if (WA_W < 2 || WA_W > 10) begin : g_bad_wa
         $error("ee3w_slave: WA_W must lie in 2..10");
      end
   endgenerate

   // ---------------- pin synchronization and edges ----------------
   logic [2:0] pin_s;
   logic       cs_s, sk_s, di_s, cs_d, sk_d;
   logic       cs_rise, cs_fall, sk_rise;

   ee3w_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({cs_i, sk_i, di_i}),
      .q_o    (pin_s)
   );

   assign cs_s = pin_s[2];
   assign sk_s = pin_s[1];
   assign di_s = pin_s[0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_d <= 1'b0;
         sk_d <= 1'b0;
      end else begin
         cs_d <= cs_s;
         sk_d <= sk_s;
      end
   end

   assign cs_rise = cs_s & ~cs_d;
   assign cs_fall = ~cs_s & cs_d;
   assign sk_rise = sk_s & ~sk_d;

   // ---------------- state ----------------
   ee3w_state_e     state_q;
   logic [HDR_W-1:0] hdr_q;
   logic [HC_W-1:0]  hcnt_q;
   logic [BA_W-1:0]  addr_q;
   logic [15:0]      dsr_q, wdat_q;
   logic [3:0]       dcnt_q, bidx_q;
   logic             dout_q, wen_q, status_q, fill_q;
   logic             go_one_q, go_all_q;
   logic             busy;
   logic [15:0]      rd_word;

   // ---------------- header decode ----------------
   logic [HDR_W-1:0] hdr_nx;
   logic [HC_W-1:0]  hdr_last;
   logic [1:0]       op, sub;
   logic [BA_W-1:0]  fld, addr_inc, addr_nx;
   logic [3:0]       dw_m1;
   logic [15:0]      dsr_nx;

   assign hdr_nx   = {hdr_q[HDR_W-2:0], di_s};
   assign hdr_last = org_i ? HC_W'(HDR_W - 2) : HC_W'(HDR_W - 1);
   assign op       = org_i ? hdr_nx[WA_W+1:WA_W]   : hdr_nx[WA_W+2:WA_W+1];
   assign sub      = org_i ? hdr_nx[WA_W-1:WA_W-2] : hdr_nx[WA_W:WA_W-1];
   assign fld      = org_i ? {1'b0, hdr_nx[WA_W-1:0]} : hdr_nx[BA_W-1:0];
   assign dw_m1    = org_i ? 4'd15 : 4'd7;
   assign dsr_nx   = {dsr_q[14:0], di_s};
   assign addr_inc = addr_q + 1'b1;
   assign addr_nx  = org_i ? {1'b0, addr_inc[WA_W-1:0]} : addr_inc;

   // ---------------- control ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= S_IDLE;
         hdr_q    <= '0;
         hcnt_q   <= '0;
         addr_q   <= '0;
         dsr_q    <= '0;
         wdat_q   <= '0;
         dcnt_q   <= '0;
         bidx_q   <= '0;
         dout_q   <= 1'b0;
         wen_q    <= 1'b0;
         status_q <= 1'b0;
         fill_q   <= 1'b0;
         go_one_q <= 1'b0;
         go_all_q <= 1'b0;
      end else begin
         go_one_q <= 1'b0;
         go_all_q <= 1'b0;
         if (cs_rise && busy) status_q <= 1'b1;
         if (cs_fall) begin
            state_q  <= S_IDLE;
            status_q <= 1'b0;
         end else begin
            case (state_q)
               S_IDLE: begin
                  if (cs_s && sk_rise && di_s && !busy) begin
                     state_q  <= S_HDR;
                     hdr_q    <= '0;
                     hcnt_q   <= '0;
                     status_q <= 1'b0;
                  end
               end
               S_HDR: begin
                  if (sk_rise) begin
                     hdr_q  <= hdr_nx;
                     hcnt_q <= hcnt_q + 1'b1;
                     if (hcnt_q == hdr_last) begin
                        addr_q <= fld;
                        case (op)
                           OP_READ: begin
                              bidx_q  <= dw_m1;
                              dout_q  <= 1'b0;
                              state_q <= S_READ;
                           end
                           OP_WRITE: begin
                              fill_q  <= 1'b0;
                              dcnt_q  <= '0;
                              state_q <= S_DATA;
                           end
                           OP_ERASE: begin
                              wdat_q   <= 16'hFFFF;
                              go_one_q <= wen_q;
                              state_q  <= S_HOLD;
                           end
                           default: begin
                              state_q <= S_HOLD;
                              case (sub)
                                 SUB_UNLOCK: wen_q <= 1'b1;
                                 SUB_LOCK:   wen_q <= 1'b0;
                                 SUB_CLRALL: begin
                                    wdat_q   <= 16'hFFFF;
                                    go_all_q <= wen_q;
                                 end
                                 default: begin
                                    fill_q  <= 1'b1;
                                    dcnt_q  <= '0;
                                    state_q <= S_DATA;
                                 end
                              endcase
                           end
                        endcase
                     end
                  end
               end
               S_DATA: begin
                  if (sk_rise) begin
                     dsr_q  <= dsr_nx;
                     dcnt_q <= dcnt_q + 1'b1;
                     if (dcnt_q == dw_m1) begin
                        wdat_q   <= org_i ? dsr_nx : {8'h00, dsr_nx[7:0]};
                        go_one_q <= wen_q & ~fill_q;
                        go_all_q <= wen_q & fill_q;
                        state_q  <= S_HOLD;
                     end
                  end
               end
               S_READ: begin
                  if (sk_rise) begin
                     dout_q <= rd_word[bidx_q];
                     if (bidx_q == 4'd0) begin
                        bidx_q <= dw_m1;
                        addr_q <= addr_nx;
                     end else begin
                        bidx_q <= bidx_q - 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // ---------------- datapath instances ----------------
   ee3w_array #(.WA_W(WA_W)) u_array (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wide_i   (org_i),
      .addr_i   (addr_q),
      .we_one_i (go_one_q),
      .we_all_i (go_all_q),
      .wdata_i  (wdat_q),
      .rdata_o  (rd_word)
   );

   ee3w_timer #(.CYCLES(PROG_CYC)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (go_one_q | go_all_q),
      .busy_o  (busy)
   );

   assign do_o    = status_q ? ~busy : dout_q;
   assign do_oe_o = cs_s & (status_q | (state_q == S_READ));

   // ---------------- assertions ----------------
   p_oe_needs_cs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      do_oe_o |-> cs_s);

   p_dummy_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(state_q == S_READ) |-> !do_o);

   p_prog_unlocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go_one_q || go_all_q) |-> wen_q);

   p_busy_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |-> (state_q == S_IDLE || state_q == S_HOLD));

endmodule

// File: tb/tb_ee3w_slave.sv
module tb_ee3w_slave;

   localparam int CLK_PERIOD = 10;
   localparam int HALF_T     = 8 * CLK_PERIOD;
   localparam int WA         = 6;
   localparam int PROG       = 2000;

   logic clk = 1'b0;
   logic rst_n, org, cs, sk, di;
   logic do_o, do_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   ee3w_slave #(.WA_W(WA), .PROG_CYC(PROG), .SYNC_STAGES(2)) dut (
      .clk_i(clk), .rst_ni(rst_n), .org_i(org),
      .cs_i(cs), .sk_i(sk), .di_i(di),
      .do_o(do_o), .do_oe_o(do_oe)
   );

   typedef struct {
      logic  e_do;
      logic  e_oe;
      string tag;
   } exp_t;

   exp_t  sbq[$];
   event  smp;
   int    checks = 0;
   int    errors = 0;
   bit    done   = 0;

   logic [7:0] refm [1 << (WA + 1)];
   bit         ref_en = 0;

   // ---------------- monitor ----------------
   initial begin
      forever begin
         @(smp);
         while (sbq.size() > 0) begin
            exp_t it;
            it = sbq.pop_front();
            checks++;
            if (do_oe !== it.e_oe || (it.e_oe && do_o !== it.e_do)) begin
               errors++;
               $display("FAIL %s: actual do=%b oe=%b expected do=%b oe=%b",
                        it.tag, do_o, do_oe, it.e_do, it.e_oe);
            end
         end
      end
   end

   task automatic chk_out(input logic e_do, input logic e_oe, input string tag);
      exp_t it;
      it.e_do = e_do;
      it.e_oe = e_oe;
      it.tag  = tag;
      sbq.push_back(it);
      ->smp;
   endtask

   // ---------------- reference model ----------------
   function automatic logic [15:0] ref_word(input bit o, input int a);
      if (o) return {refm[2*a+1], refm[2*a]};
      return {8'h00, refm[a]};
   endfunction

   function automatic int dwid(input bit o);
      return o ? 16 : 8;
   endfunction

   function automatic int awid(input bit o);
      return o ? WA : WA + 1;
   endfunction

   // ---------------- driver ----------------
   task automatic pulse(input logic b, input bit chk, input logic e_do, input string tag);
      di = b;
      #(HALF_T);
      sk = 1'b1;
      #(HALF_T);
      if (chk) chk_out(e_do, 1'b1, tag);
      sk = 1'b0;
   endtask

   task automatic cs_up();
      #(HALF_T);
      cs = 1'b1;
      #(HALF_T);
   endtask

   task automatic cs_down();
      #(HALF_T);
      cs = 1'b0;
      di = 1'b0;
      #(4 * HALF_T);
   endtask

   task automatic send_hdr(input bit o, input logic [1:0] op, input logic [7:0] a, input bit dchk);
      pulse(1'b1, 0, 1'b0, "");
      pulse(op[1], 0, 1'b0, "");
      pulse(op[0], 0, 1'b0, "");
      for (int i = awid(o) - 1; i >= 0; i--)
         pulse(a[i], dchk && (i == 0), 1'b0, "R2 dummy bit");
   endtask

   task automatic send_data(input bit o, input logic [15:0] d);
      for (int b = dwid(o) - 1; b >= 0; b--) pulse(d[b], 0, 1'b0, "");
   endtask

   task automatic settle();
      #(CLK_PERIOD * (PROG + 50));
   endtask

   task automatic read_seq(input bit o, input int a, input int nw, input int lead, input string tag);
      org = o;
      cs_up();
      for (int z = 0; z < lead; z++) pulse(1'b0, 0, 1'b0, "");
      send_hdr(o, 2'b10, 8'(a), 1);
      for (int w = 0; w < nw; w++) begin
         logic [15:0] word;
         word = ref_word(o, (a + w) % (1 << awid(o)));
         for (int b = dwid(o) - 1; b >= 0; b--) pulse(1'b0, 1, word[b], tag);
      end
      cs_down();
      chk_out(1'b0, 1'b0, "R10 released after cs low");
   endtask

   task automatic status_chk();
      cs_up();
      chk_out(1'b0, 1'b1, "R9 busy early");
      #(CLK_PERIOD * (PROG - 300));
      chk_out(1'b0, 1'b1, "R9 busy late");
      #(CLK_PERIOD * 350);
      chk_out(1'b1, 1'b1, "R9 ready");
      cs_down();
   endtask

   task automatic write_w(input bit o, input int a, input logic [15:0] d, input bit stat);
      org = o;
      cs_up();
      send_hdr(o, 2'b01, 8'(a), 0);
      send_data(o, d);
      cs_down();
      if (ref_en) begin
         if (o) begin
            refm[2*a]   = d[7:0];
            refm[2*a+1] = d[15:8];
         end else begin
            refm[a] = d[7:0];
         end
      end
      if (stat) status_chk();
      else settle();
   endtask

   task automatic erase_w(input bit o, input int a);
      org = o;
      cs_up();
      send_hdr(o, 2'b11, 8'(a), 0);
      cs_down();
      if (ref_en) begin
         if (o) begin
            refm[2*a]   = 8'hFF;
            refm[2*a+1] = 8'hFF;
         end else begin
            refm[a] = 8'hFF;
         end
      end
      settle();
   endtask

   task automatic ext_cmd(input bit o, input logic [1:0] sb, input logic [15:0] d);
      logic [7:0] av;
      org = o;
      av = 8'(sb) << (awid(o) - 2);
      cs_up();
      send_hdr(o, 2'b00, av, 0);
      if (sb == 2'b01) send_data(o, d);
      cs_down();
      case (sb)
         2'b11: ref_en = 1;
         2'b00: ref_en = 0;
         2'b10: if (ref_en) for (int i = 0; i < (1 << (WA + 1)); i++) refm[i] = 8'hFF;
         default: if (ref_en)
            for (int i = 0; i < (1 << (WA + 1)); i++)
               refm[i] = (o && (i % 2 == 1)) ? d[15:8] : d[7:0];
      endcase
      if (sb == 2'b01 || sb == 2'b10) settle();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int i = 0; i < (1 << (WA + 1)); i++) refm[i] = 8'hFF;
      rst_n = 1'b0; org = 1'b1; cs = 1'b0; sk = 1'b0; di = 1'b0;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #(CLK_PERIOD / 2 + 2);

      // R5: reset state, output released and array erased
      chk_out(1'b0, 1'b0, "R5 reset oe low");
      read_seq(1, 0, 1, 0, "R5 erased after reset");

      // R6: programming locked after reset, read still works
      write_w(1, 3, 16'h1234, 0);
      read_seq(1, 3, 1, 0, "R6 locked write ignored");

      // R6/R7/R9: unlock, write with status polling
      ext_cmd(1, 2'b11, 16'h0);
      write_w(1, 3, 16'hA55A, 1);
      read_seq(1, 3, 1, 0, "R7 word write");

      // R4/R3: byte view of the same word, streamed
      read_seq(0, 6, 2, 0, "R4 byte view of word");

      // R7 in 8-bit mode, R3 stream across neighbours
      write_w(0, 9, 16'h003C, 0);
      read_seq(0, 8, 3, 0, "R3 byte stream");

      // R3: wrap from the last word to word 0
      write_w(0, 127, 16'h0081, 0);
      write_w(0, 0, 16'h0042, 0);
      read_seq(1, 63, 2, 0, "R3 wrap to zero");

      // R8: single-word erase
      erase_w(1, 3);
      read_seq(1, 3, 1, 0, "R8 word erase");

      // R11: instruction sent during busy is ignored
      org = 1'b1;
      cs_up();
      send_hdr(1, 2'b01, 8'd5, 0);
      send_data(1, 16'h1111);
      cs_down();
      refm[10] = 8'h11; refm[11] = 8'h11;
      cs_up();
      send_hdr(1, 2'b01, 8'd6, 0);
      send_data(1, 16'h2222);
      cs_down();
      settle();
      read_seq(1, 5, 2, 0, "R11 busy instruction ignored");

      // R8: write-all in 16-bit mode, viewed both ways
      ext_cmd(1, 2'b01, 16'hBEEF);
      read_seq(1, 10, 2, 0, "R8 write all");
      read_seq(0, 21, 1, 0, "R8 write all byte view");

      // R8 erase-all, R10 no status when cs raised after completion
      ext_cmd(0, 2'b10, 16'h0);
      org = 1'b0;
      cs_up();
      chk_out(1'b0, 1'b0, "R10 no status after completion");
      cs_down();
      read_seq(0, 0, 2, 0, "R8 erase all");

      // R6: lock again, write has no effect
      ext_cmd(1, 2'b00, 16'h0);
      write_w(1, 1, 16'h0F0F, 0);
      read_seq(1, 1, 1, 0, "R6 relocked write ignored");

      // R1: leading zeros before the start bit are skipped
      read_seq(1, 10, 1, 3, "R1 leading zeros skipped");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule